// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffers

This block sits beside a data cache and turns its load misses into hits on lines that were fetched ahead of time. It keeps several small queues, each tied to one run of consecutive cache-line addresses. When the cache reports a miss, only the oldest entry of every queue is compared with the missing line. If one of them matches and its data has arrived, that entry leaves the queue and its data goes back to the cache one cycle later. If the matching entry is still waiting on memory, the miss is held until the data lands. If nothing matches, a queue is given to a new stream that starts at the line after the miss. A free queue is chosen first. When every queue is in use, the one used least recently is taken.

Each queue with a free slot asks memory for the line after the last one it requested. When several queues want the bus, they take turns. A request leaves only when memory shows it can take one. Every request carries a tag naming the queue, the slot and a stream generation. A response that still arrives for a stream whose queue has since been reassigned is dropped.

Top module: `spf_prefetcher`

## Requirements
- R1: After reset no memory request is raised, `fill_valid_o` and `nohit_o` are low and `miss_ready_o` is high.
- R2: A miss whose line matches no queue head is accepted at once. `nohit_o` is high for exactly the one cycle after acceptance. The chosen queue then requests lines miss+1, miss+2, ... in that order, up to `BUF_DEPTH` lines, starting in the cycle after acceptance.
- R3: A miss whose line matches a head with data present gives `fill_valid_o` high in the cycle after acceptance, with `fill_addr_o` equal to the miss line and `fill_data_o` equal to the data memory returned for it. The entry is removed, so a second miss to the same line reports `nohit_o`.
- R4: Only the head of each queue is compared. A miss to a line held in a later entry of a queue is treated as no match.
- R5: While the matching head is still waiting for memory, `miss_ready_o` is low and no result is produced. The miss is accepted in the cycle after the response is written.
- R6: Once a queue has a free slot, it requests the line after the last one it requested, continuing its own sequence across pops.
- R7: While `mem_req_ready_i` is low, a raised request keeps the same address and tag, and no slot is used up.
- R8: A new stream takes the lowest-numbered unused queue. If all queues are in use, it takes the queue least recently allocated or hit. When more than one head matches, the lowest-numbered queue serves the miss.
- R9: When several queues have requests pending, grants go round-robin. After queue i is granted, the search starts at queue i+1.
- R10: `mem_req_tag_o` is {queue index, slot index, generation}, with the generation in the low `GEN_W` bits and the queue index in the top bits. Reassigning a queue advances its generation (reset value 0). A response whose generation differs from the queue's current one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Cache reports a load miss |
| miss_addr_i | input | ADDR_W | Line address of the miss |
| miss_ready_o | output | 1 | Miss can be accepted this cycle |
| fill_valid_o | output | 1 | Prefetched line is returned to the cache |
| fill_addr_o | output | ADDR_W | Line address of the returned line |
| fill_data_o | output | DATA_W | Returned line data |
| nohit_o | output | 1 | Last accepted miss matched no head |
| mem_req_valid_o | output | 1 | Prefetch request to memory |
| mem_req_addr_o | output | ADDR_W | Requested line address |
| mem_req_tag_o | output | TAG_W | Request tag {queue, slot, generation} |
| mem_req_ready_i | input | 1 | Memory bus can take a request |
| mem_resp_valid_i | input | 1 | Memory returns a line |
| mem_resp_tag_i | input | TAG_W | Tag echoed with the response |
| mem_resp_data_i | input | DATA_W | Returned line data |

## Verification
Fill and no-match results are registered, so they are due in the first cycle after the edge that accepts the miss. The bench samples them at the falling edge that follows that acceptance edge. A new stream's first request appears combinationally in that same cycle, and each later request leaves one cycle after the previous one. A stalled miss becomes ready one cycle after its response is driven and gives its fill one cycle later. Request order is checked from a log the bench records at the edges where the handshake completes. Every expected address, tag and data word is computed in the bench from the line number.

// File: rtl/spf_pkg.sv
package spf_pkg;
  // Outcome of the miss port in the current cycle
  typedef enum logic [1:0] {
    MO_IDLE  = 2'd0,
    MO_HIT   = 2'd1,
    MO_ALLOC = 2'd2,
    MO_STALL = 2'd3
  } miss_outcome_e;
endpackage

// File: rtl/spf_lru.sv
module spf_lru #(
  parameter  int NB   = 4,
  localparam int BI_W = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            touch_i,
  input  logic [BI_W-1:0] touch_idx_i,
  output logic [BI_W-1:0] lru_idx_o
);
  // rank 0 = most recent, NB-1 = least recent
  logic [BI_W-1:0] rank [NB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) rank[i] <= BI_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < NB; i++) begin
        if (BI_W'(i) == touch_idx_i) rank[i] <= '0;
        else if (rank[i] < rank[touch_idx_i]) rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < NB; i++)
      if (rank[i] == BI_W'(NB-1)) lru_idx_o = BI_W'(i);
  end

  // R8: a queue just touched is never the next victim
  a_r8_touched_not_lru: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> lru_idx_o != $past(touch_idx_i));
endmodule

// File: rtl/spf_rr_arb.sv
module spf_rr_arb #(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          en_i,
  output logic          any_o,
  output logic          fire_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] last_q;

  // First requester after prev, wrapping around
  function automatic logic [IW-1:0] rr_pick(input logic [N-1:0] req,
                                            input logic [IW-1:0] prev);
    logic [IW-1:0] pick;
    int idx;
    pick = prev;
    for (int k = N; k >= 1; k--) begin
      idx = (int'(prev) + k) % N;
      if (req[idx]) pick = IW'(idx);
    end
    return pick;
  endfunction

  assign any_o     = |req_i;
  assign gnt_idx_o = rr_pick(req_i, last_q);
  assign fire_o    = any_o && en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N-1);
    else if (fire_o) last_q <= gnt_idx_o;
  end

  a_r9_grant_is_requester: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[gnt_idx_o]);
  a_r9_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && $countones(req_i) > 1 |=>
      !(fire_o && $stable(req_i) && gnt_idx_o == $past(gnt_idx_o)));
endmodule

// File: rtl/spf_stream_buf.sv
module spf_stream_buf #(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 4,
  parameter  int GEN_W  = 2,
  localparam int SL_W   = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              pop_i,
  input  logic              issue_i,
  input  logic              resp_i,
  input  logic [SL_W-1:0]   resp_slot_i,
  input  logic [GEN_W-1:0]  resp_gen_i,
  input  logic [DATA_W-1:0] resp_data_i,
  output logic              active_o,
  output logic              head_valid_o,
  output logic              head_pending_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              want_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [SL_W-1:0]   fetch_slot_o,
  output logic [GEN_W-1:0]  gen_o
);
  logic              active_q;
  logic [DEPTH-1:0]  vld_q, pend_q;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [SL_W-1:0]   hd_q, tl_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] nxt_q;
  logic [GEN_W-1:0]  gen_q;
  logic              resp_ok;

  function automatic logic [SL_W-1:0] ptr_inc(input logic [SL_W-1:0] p);
    return (p == SL_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] line_after(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  assign resp_ok = resp_i && resp_gen_i == gen_q &&
                   vld_q[resp_slot_i] && pend_q[resp_slot_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      vld_q    <= '0;
      pend_q   <= '0;
      hd_q     <= '0;
      tl_q     <= '0;
      cnt_q    <= '0;
      nxt_q    <= '0;
      gen_q    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (resp_ok) begin
        data_q[resp_slot_i] <= resp_data_i;
        pend_q[resp_slot_i] <= 1'b0;
      end
      if (alloc_i) begin
        active_q <= 1'b1;
        gen_q    <= gen_q + 1'b1;
        nxt_q    <= alloc_addr_i;
        hd_q     <= '0;
        tl_q     <= '0;
        cnt_q    <= '0;
        vld_q    <= '0;
        pend_q   <= '0;
      end else begin
        if (issue_i) begin
          vld_q[tl_q]  <= 1'b1;
          pend_q[tl_q] <= 1'b1;
          addr_q[tl_q] <= nxt_q;
          tl_q         <= ptr_inc(tl_q);
          nxt_q        <= line_after(nxt_q);
        end
        if (pop_i) begin
          vld_q[hd_q] <= 1'b0;
          hd_q        <= ptr_inc(hd_q);
        end
        cnt_q <= cnt_q + CW'(issue_i) - CW'(pop_i);
      end
    end
  end

  assign active_o       = active_q;
  assign head_valid_o   = vld_q[hd_q];
  assign head_pending_o = pend_q[hd_q];
  assign head_addr_o    = addr_q[hd_q];
  assign head_data_o    = data_q[hd_q];
  assign want_o         = active_q && cnt_q < CW'(DEPTH);
  assign fetch_addr_o   = nxt_q;
  assign fetch_slot_o   = tl_q;
  assign gen_o          = gen_q;

  a_r6_no_issue_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> cnt_q < CW'(DEPTH));
  a_r3_pop_only_ready_head: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> vld_q[hd_q] && !pend_q[hd_q]);
  a_r2_lines_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && cnt_q != '0 |-> nxt_q == addr_q[hd_q] + ADDR_W'(cnt_q));
endmodule

// File: rtl/spf_prefetcher.sv
module spf_prefetcher #(
  parameter  int NUM_BUF   = 4,
  parameter  int BUF_DEPTH = 4,
  parameter  int ADDR_W    = 16,
  parameter  int DATA_W    = 32,
  parameter  int GEN_W     = 2,
  localparam int BI_W      = $clog2(NUM_BUF),
  localparam int SL_W      = $clog2(BUF_DEPTH),
  localparam int TAG_W     = BI_W + SL_W + GEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              miss_ready_o,
  output logic              fill_valid_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic              nohit_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [TAG_W-1:0]  mem_req_tag_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_resp_valid_i,
  input  logic [TAG_W-1:0]  mem_resp_tag_i,
  input  logic [DATA_W-1:0] mem_resp_data_i
);
  import spf_pkg::*;

  logic [NUM_BUF-1:0] active, head_valid, head_pend, want, want_m;
  logic [NUM_BUF-1:0] head_match, alloc_vec, pop_vec, issue_vec, resp_vec;
  logic [ADDR_W-1:0]  head_addr  [NUM_BUF];
  logic [DATA_W-1:0]  head_data  [NUM_BUF];
  logic [ADDR_W-1:0]  fetch_addr [NUM_BUF];
  logic [SL_W-1:0]    fetch_slot [NUM_BUF];
  logic [GEN_W-1:0]   gen        [NUM_BUF];

  logic              hit_any, free_any, arb_fire, arb_any, touch;
  logic [BI_W-1:0]   hit_idx, free_idx, lru_idx, victim, gnt_idx, touch_idx;
  logic [BI_W-1:0]   rsp_buf;
  logic [SL_W-1:0]   rsp_slot;
  logic [GEN_W-1:0]  rsp_gen;
  logic              ev_hit, ev_alloc;
  miss_outcome_e     outcome;

  // ---------------- head compare, lowest index wins ----------------
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NUM_BUF-1; i >= 0; i--) begin
      head_match[i] = head_valid[i] && head_addr[i] == miss_addr_i;
      if (head_match[i]) begin
        hit_any = 1'b1;
        hit_idx = BI_W'(i);
      end
    end
  end

  always_comb begin
    if (!miss_valid_i)        outcome = MO_IDLE;
    else if (!hit_any)        outcome = MO_ALLOC;
    else if (head_pend[hit_idx]) outcome = MO_STALL;
    else                      outcome = MO_HIT;
  end

  assign miss_ready_o = !(hit_any && head_pend[hit_idx]);
  assign ev_hit       = outcome == MO_HIT;
  assign ev_alloc     = outcome == MO_ALLOC;

  // ---------------- victim choice ----------------
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NUM_BUF-1; i >= 0; i--)
      if (!active[i]) begin
        free_any = 1'b1;
        free_idx = BI_W'(i);
      end
  end

  assign victim    = free_any ? free_idx : lru_idx;
  assign touch     = ev_hit || ev_alloc;
  assign touch_idx = ev_hit ? hit_idx : victim;

  spf_lru #(.NB(NUM_BUF)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_i(touch),
    .touch_idx_i(touch_idx), .lru_idx_o(lru_idx)
  );

  // ---------------- request arbitration ----------------
  spf_rr_arb #(.N(NUM_BUF)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(want_m), .en_i(mem_req_ready_i),
    .any_o(arb_any), .fire_o(arb_fire), .gnt_idx_o(gnt_idx)
  );

  assign mem_req_valid_o = arb_any;
  assign mem_req_addr_o  = fetch_addr[gnt_idx];
  assign mem_req_tag_o   = {gnt_idx, fetch_slot[gnt_idx], gen[gnt_idx]};

  // ---------------- response tag decode ----------------
  assign rsp_buf  = mem_resp_tag_i[TAG_W-1 -: BI_W];
  assign rsp_slot = mem_resp_tag_i[GEN_W +: SL_W];
  assign rsp_gen  = mem_resp_tag_i[GEN_W-1:0];

  // ---------------- the queues ----------------
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    assign alloc_vec[g] = ev_alloc && victim == BI_W'(g);
    assign pop_vec[g]   = ev_hit && hit_idx == BI_W'(g);
    assign want_m[g]    = want[g] && !alloc_vec[g];
    assign issue_vec[g] = arb_fire && gnt_idx == BI_W'(g);
    assign resp_vec[g]  = mem_resp_valid_i && rsp_buf == BI_W'(g);

    spf_stream_buf #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(BUF_DEPTH), .GEN_W(GEN_W)
    ) u_buf (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_vec[g]), .alloc_addr_i(miss_addr_i + 1'b1),
      .pop_i(pop_vec[g]), .issue_i(issue_vec[g]),
      .resp_i(resp_vec[g]), .resp_slot_i(rsp_slot), .resp_gen_i(rsp_gen),
      .resp_data_i(mem_resp_data_i),
      .active_o(active[g]), .head_valid_o(head_valid[g]),
      .head_pending_o(head_pend[g]), .head_addr_o(head_addr[g]),
      .head_data_o(head_data[g]), .want_o(want[g]),
      .fetch_addr_o(fetch_addr[g]), .fetch_slot_o(fetch_slot[g]),
      .gen_o(gen[g])
    );
  end

  // ---------------- registered results ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_valid_o <= 1'b0;
      fill_addr_o  <= '0;
      fill_data_o  <= '0;
      nohit_o      <= 1'b0;
    end else begin
      fill_valid_o <= ev_hit;
      nohit_o      <= ev_alloc;
      if (ev_hit) begin
        fill_addr_o <= miss_addr_i;
        fill_data_o <= head_data[hit_idx];
      end
    end
  end

  a_r5_stall_gives_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid_i && !miss_ready_o |=> !fill_valid_o && !nohit_o);
  a_r3_fill_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid_o |-> $past(miss_valid_i && miss_ready_o) && fill_addr_o == $past(miss_addr_i));
  a_r2_new_stream_requests: assert property (@(posedge clk) disable iff (!rst_n)
    nohit_o |-> mem_req_valid_o);
  a_r7_held_request_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i && !miss_valid_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_tag_o));
  a_r2_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid_o && nohit_o));
endmodule

// File: tb/sim_spf_prefetcher.sv
`timescale 1ns/1ps
module sim_spf_prefetcher;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 4;   // 1 queue bit, 1 slot bit, 2 generation bits

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic          miss_ready;
  logic          fill_valid;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic          nohit;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag;
  logic          mem_req_ready = 1'b1;
  logic          mem_resp_valid = 1'b0;
  logic [TW-1:0] mem_resp_tag = '0;
  logic [DW-1:0] mem_resp_data = '0;

  int nchk = 0;
  int nfail = 0;
  logic [AW-1:0] lg_addr [64];
  logic [TW-1:0] lg_tag  [64];
  int nreq;

  logic          fv, nh;
  logic [AW-1:0] fa;
  logic [DW-1:0] fd;

  always #2 clk = ~clk;

  spf_prefetcher #(
    .NUM_BUF(2), .BUF_DEPTH(2), .ADDR_W(AW), .DATA_W(DW), .GEN_W(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr), .miss_ready_o(miss_ready),
    .fill_valid_o(fill_valid), .fill_addr_o(fill_addr), .fill_data_o(fill_data),
    .nohit_o(nohit),
    .mem_req_valid_o(mem_req_valid), .mem_req_addr_o(mem_req_addr),
    .mem_req_tag_o(mem_req_tag), .mem_req_ready_i(mem_req_ready),
    .mem_resp_valid_i(mem_resp_valid), .mem_resp_tag_i(mem_resp_tag),
    .mem_resp_data_i(mem_resp_data)
  );

  // log of completed request handshakes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) nreq <= 0;
    else if (mem_req_valid && mem_req_ready) begin
      lg_addr[nreq % 64] <= mem_req_addr;
      lg_tag[nreq % 64]  <= mem_req_tag;
      nreq <= nreq + 1;
    end
  end

  function automatic logic [DW-1:0] dat(input logic [AW-1:0] a);
    return {a ^ 16'hC3A5, a};
  endfunction

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; miss_valid = 1'b0; mem_resp_valid = 1'b0; mem_req_ready = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic do_miss(input logic [AW-1:0] a);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a; #1;
    while (!miss_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    miss_valid = 1'b0;
    fv = fill_valid; nh = nohit; fa = fill_addr; fd = fill_data;
  endtask

  // drive the response for logged request k for one cycle
  task automatic respond(input int k);
    mem_resp_valid = 1'b1; mem_resp_tag = lg_tag[k]; mem_resp_data = dat(lg_addr[k]);
    @(negedge clk);
    mem_resp_valid = 1'b0;
  endtask

  task automatic stalled_hit(input logic [AW-1:0] a, input int k, input int stale, input string r);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a; #1;
    check({r, " stalled"}, miss_ready, 0);
    if (stale >= 0) respond(stale);
    @(negedge clk); #1;
    check({r, " still stalled"}, miss_ready, 0);
    check({r, " no fill in stall"}, fill_valid, 0);
    respond(k);
    #1 check({r, " ready after data"}, miss_ready, 1);
    @(negedge clk);
    miss_valid = 1'b0;
    check({r, " fill valid"}, fill_valid, 1);
    check({r, " fill addr"}, fill_addr, a);
    check({r, " fill data"}, fill_data, dat(a));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // ---- R1: reset state ----
    reset_dut();
    #1;
    check("R1 no request", mem_req_valid, 0);
    check("R1 no fill", fill_valid, 0);
    check("R1 no nohit", nohit, 0);
    check("R1 ready", miss_ready, 1);

    // ---- R2: new stream ----
    do_miss(16'h0100);
    check("R2 nohit", nh, 1);
    check("R2 no fill", fv, 0);
    check("R2 first request up", mem_req_valid, 1);
    check("R2 first request addr", mem_req_addr, 16'h0101);
    wait_cyc(1);
    check("R2 nohit one cycle", nohit, 0);
    wait_cyc(3);
    check("R2 request count", nreq, 2);
    check("R2 line 1", lg_addr[0], 16'h0101);
    check("R2 line 2", lg_addr[1], 16'h0102);
    check("R10 tag q0 s0 g1", lg_tag[0], 4'b0001);
    check("R10 tag q0 s1 g1", lg_tag[1], 4'b0101);

    // ---- R5: pending head stalls, then R3 fill ----
    stalled_hit(16'h0101, 0, -1, "R5");
    wait_cyc(3);
    check("R6 refill count", nreq, 3);
    check("R6 refill line", lg_addr[2], 16'h0103);
    respond(1);
    respond(2);

    // ---- R4: non-head line does not match ----
    do_miss(16'h0103);
    check("R4 non-head nohit", nh, 1);
    check("R4 non-head no fill", fv, 0);
    wait_cyc(4);
    check("R8 free queue used", lg_tag[3][3], 1);
    check("R8 free queue line", lg_addr[3], 16'h0104);

    // ---- R3: hit with data present ----
    do_miss(16'h0102);
    check("R3 fill valid", fv, 1);
    check("R3 fill addr", fa, 16'h0102);
    check("R3 fill data", fd, dat(16'h0102));
    check("R3 nohit low", nh, 0);
    wait_cyc(4);
    check("R6 continues sequence", lg_addr[5], 16'h0104);
    check("R6 same queue", lg_tag[5][3], 0);

    // ---- R3 removal, R8 LRU recycle ----
    do_miss(16'h0102);
    check("R3 popped entry gone", nh, 1);
    wait_cyc(4);
    check("R8 LRU victim", lg_tag[6][3], 1);
    check("R8 LRU victim line", lg_addr[6], 16'h0103);
    do_miss(16'h0103);
    check("R8 recent queue kept", fv, 1);
    check("R8 recent queue data", fd, dat(16'h0103));

    // ---- R10: stale response after reassignment ----
    reset_dut();
    do_miss(16'h0200); wait_cyc(4);
    do_miss(16'h0300); wait_cyc(4);
    do_miss(16'h0400); wait_cyc(4);
    check("R10 reassign count", nreq, 6);
    check("R10 reassigned line", lg_addr[4], 16'h0401);
    check("R10 generation advanced", lg_tag[4], 4'b0010);
    stalled_hit(16'h0401, 4, 0, "R10");

    // ---- R7 bus busy, R9 round robin ----
    reset_dut();
    mem_req_ready = 1'b0;
    do_miss(16'h0500);
    wait_cyc(2);
    check("R7 request held", mem_req_valid, 1);
    check("R7 held addr", mem_req_addr, 16'h0501);
    wait_cyc(2);
    check("R7 held addr later", mem_req_addr, 16'h0501);
    check("R7 held tag", mem_req_tag, 4'b0001);
    check("R7 nothing sent", nreq, 0);
    do_miss(16'h0600);
    mem_req_ready = 1'b1;
    wait_cyc(6);
    check("R9 grant count", nreq, 4);
    check("R9 grant 0", lg_addr[0], 16'h0501);
    check("R9 grant 1", lg_addr[1], 16'h0601);
    check("R9 grant 2", lg_addr[2], 16'h0502);
    check("R9 grant 3", lg_addr[3], 16'h0602);

    finish_run();
  end
endmodule